// File: doc/BRIEF.md
# Binary64 Minimum/Maximum Selector

This unit picks the smaller or the larger of two IEEE-754 double-precision operands and keeps a sticky invalid-operation flag beside the result. One control bit chooses the operation (minimum or maximum). A strobe launches each operation, and one cycle later the registered result appears together with a matching valid pulse.

Most of its logic deals with NaN inputs. A single NaN is dropped and the other operand wins. Two NaNs give a fixed all-ones word. The invalid flag is raised only when a signaling NaN is present, and infinities never raise it. Ordinary values are ordered by sign and magnitude, so negative zero ranks below positive zero. The flag stays set until software pulses a clear line. A clear in the same cycle as a new set wins.

Top module: `fpmm_unit`

## Requirements
- R1: When exactly one operand is a NaN (exponent field bits 62:52 all ones and mantissa bits 51:0 nonzero), the result is the other operand, for both minimum and maximum.
- R2: When both operands are NaN, the result is 64'hFFFF_FFFF_FFFF_FFFF, for both operations and any mix of quiet and signaling NaNs.
- R3: A NaN with mantissa bit 51 equal to 0 is signaling. If either operand of an accepted operation is signaling, the invalid flag is 1 after that operation.
- R4: A NaN with mantissa bit 51 equal to 1 is quiet. Operations whose NaN operands are all quiet leave the invalid flag unchanged.
- R5: The invalid flag is sticky. Once set, it stays at 1 through later operations until a clear pulse.
- R6: A clear pulse (`flag_clr` = 1 at a clock edge) forces the flag to 0, even when an operation with a signaling NaN is accepted at the same edge.
- R7: For non-NaN operands, `sel_max` = 0 returns the lesser value and `sel_max` = 1 returns the greater value. Order follows the sign first, then the magnitude, with the magnitude order reversed for negative values.
- R8: The minimum of +0 (64'h0) and -0 (64'h8000_0000_0000_0000) is -0, and the maximum is +0, in either operand order.
- R9: Infinities are ordered above and below every finite value and never change the invalid flag.
- R10: `res_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1. The result register loads only on accepted operations and holds otherwise.
- R11: After reset, `res_valid`, `result` and `invalid_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the operands and the operation in this cycle |
| sel_max | input | 1 | 0 selects minimum, 1 selects maximum |
| op_a | input | 64 | First binary64 operand |
| op_b | input | 64 | Second binary64 operand |
| flag_clr | input | 1 | Clear the sticky invalid flag |
| result | output | 64 | Registered result |
| res_valid | output | 1 | Result was updated in the previous edge |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
Two flag functions can collide in one cycle: the set from an accepted operation with a signaling NaN, and the clear pulse. The bench issues operations that carry a signaling NaN with `flag_clr` held high in the same cycle, both directed and at random among the stimulus. The flag must read 0 afterwards, while the result is still the one the NaN rules call for. The bench's flag model applies the clear after the set, and every operation is compared against that model.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  typedef enum logic {SEL_MIN = 1'b0, SEL_MAX = 1'b1} sel_e;

  typedef struct packed {
    logic nan;
    logic sig;
  } fpcls_t;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] val,
  output fpcls_t               cls
);
  localparam int W = 1 + EXP_W + MAN_W;

  function automatic fpcls_t classify(input logic [W-1:0] v);
    fpcls_t c;
    logic exp_full;
    logic man_nz;
    exp_full = &v[W-2:MAN_W];
    man_nz   = |v[MAN_W-1:0];
    c.nan    = exp_full & man_nz;
    c.sig    = c.nan & ~v[MAN_W-1];
    return c;
  endfunction

  assign cls = classify(val);
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  sel_e                 sel,
  output logic [EXP_W+MAN_W:0] pick
);
  localparam int W = 1 + EXP_W + MAN_W;

  function automatic logic less_than(input logic [W-1:0] x, input logic [W-1:0] y);
    logic sx, sy;
    logic [W-2:0] mx, my;
    sx = x[W-1];
    sy = y[W-1];
    mx = x[W-2:0];
    my = y[W-2:0];
    if (sx != sy) return sx;
    if (sx)       return mx > my;
    return mx < my;
  endfunction

  logic a_lt_b;
  assign a_lt_b = less_than(a, b);

  always_comb begin
    if (sel == SEL_MAX) pick = a_lt_b ? b : a;
    else                pick = a_lt_b ? a : b;
  end
endmodule

// File: rtl/fpmm_sticky.sv
module fpmm_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_o);
  a_r3_set_on_signal: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> flag_o);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> (flag_o == $past(flag_o)));
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 sel_max,
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  input  logic                 flag_clr,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 res_valid,
  output logic                 invalid_flag
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] ALL_ONES = '1;

  fpcls_t cls_a, cls_b;
  logic [W-1:0] ordered;
  logic [W-1:0] next_res;
  logic both_nan, only_a_nan, only_b_nan, sig_evt, quiet_only;
  logic res_is_nan;
  sel_e sel;

  assign sel = sel_max ? SEL_MAX : SEL_MIN;

  fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (.val(op_a), .cls(cls_a));
  fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (.val(op_b), .cls(cls_b));

  fpmm_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a(op_a), .b(op_b), .sel(sel), .pick(ordered)
  );

  assign both_nan   = cls_a.nan & cls_b.nan;
  assign only_a_nan = cls_a.nan & ~cls_b.nan;
  assign only_b_nan = cls_b.nan & ~cls_a.nan;
  assign sig_evt    = in_valid & (cls_a.sig | cls_b.sig);
  assign quiet_only = (cls_a.nan | cls_b.nan) & ~cls_a.sig & ~cls_b.sig;

  always_comb begin
    if (both_nan)        next_res = ALL_ONES;
    else if (only_a_nan) next_res = op_b;
    else if (only_b_nan) next_res = op_a;
    else                 next_res = ordered;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  fpmm_sticky u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(sig_evt), .clr_i(flag_clr), .flag_o(invalid_flag)
  );

  assign res_is_nan = (&result[W-2:MAN_W]) & (|result[MAN_W-1:0]);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  a_r10_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(result)));
  a_r2_both_nan_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && both_nan) |=> (result == ALL_ONES));
  a_r1_single_nan_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!res_is_nan || result == ALL_ONES));
  a_r4_quiet_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && quiet_only && !invalid_flag) |=> !invalid_flag);
endmodule

// File: tb/fpmm_unit_tb.sv
module fpmm_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN = 64'h7FF7_0000_0000_0000;
  localparam logic [63:0] ANYV = 64'h3F80_0000_0000_0000;
  localparam logic [63:0] PZERO = 64'h0;
  localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic sel_max = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic flag_clr = 1'b0;
  logic [63:0] result;
  logic res_valid;
  logic invalid_flag;

  int checks = 0;
  int errors = 0;
  logic model_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpmm_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_max(sel_max),
    .op_a(op_a), .op_b(op_b), .flag_clr(flag_clr),
    .result(result), .res_valid(res_valid), .invalid_flag(invalid_flag)
  );

  function automatic logic is_nan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
  endfunction

  function automatic logic is_sig(input logic [63:0] v);
    return is_nan(v) && !v[51];
  endfunction

  // map to an unsigned key whose natural order is the numeric order
  function automatic logic [63:0] key(input logic [63:0] v);
    return v[63] ? ~v : (v | 64'h8000_0000_0000_0000);
  endfunction

  function automatic logic [63:0] ref_res(input logic [63:0] a, input logic [63:0] b, input logic mx);
    if (is_nan(a) && is_nan(b)) return ONES;
    if (is_nan(a)) return b;
    if (is_nan(b)) return a;
    if (mx) return (key(a) >= key(b)) ? a : b;
    return (key(a) <= key(b)) ? a : b;
  endfunction

  function automatic string res_tag(input logic [63:0] a, input logic [63:0] b);
    if (is_nan(a) && is_nan(b)) return "R2";
    if (is_nan(a) || is_nan(b)) return "R1";
    if (a[62:0] == 63'd0 && b[62:0] == 63'd0) return "R8";
    if (a[62:0] == PINF[62:0] || b[62:0] == PINF[62:0]) return "R9";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [63:0] a, input logic [63:0] b, input logic mx, input logic clr);
    logic sig;
    @(negedge clk);
    op_a = a; op_b = b; sel_max = mx; flag_clr = clr; in_valid = 1'b1;
    sig = is_sig(a) || is_sig(b);
    model_flag = clr ? 1'b0 : (model_flag | sig);
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
    check(res_tag(a, b), result, ref_res(a, b, mx));
    check("R10", {63'd0, res_valid}, 64'd1);
    if (clr)      check("R6", {63'd0, invalid_flag}, {63'd0, model_flag});
    else if (sig) check("R3", {63'd0, invalid_flag}, {63'd0, model_flag});
    else          check("R4 R5", {63'd0, invalid_flag}, {63'd0, model_flag});
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    model_flag = 1'b0;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R6", {63'd0, invalid_flag}, 64'd0);
  endtask

  function automatic logic [63:0] gen_operand();
    logic [63:0] r;
    logic s;
    r = {$urandom, $urandom};
    s = r[63];
    case ($urandom % 7)
      0: return {s, 11'h7FF, 1'b1, r[50:0]};
      1: return {s, 11'h7FF, 1'b0, r[50:1], 1'b1};
      2: return s ? NINF : PINF;
      3: return s ? NZERO : PZERO;
      default: return r;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 2 + 1);
    check("R11", result, 64'd0);
    check("R11", {63'd0, res_valid}, 64'd0);
    check("R11", {63'd0, invalid_flag}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // single NaN, quiet and signaling
    do_op(QNAN, ANYV, 1'b0, 1'b0);
    do_op(ANYV, QNAN, 1'b1, 1'b0);
    do_op(SNAN, ANYV, 1'b0, 1'b0);
    do_op(ANYV, SNAN, 1'b1, 1'b0);
    clear_flag();
    // both NaN, all mixes
    do_op(QNAN, QNAN, 1'b0, 1'b0);
    do_op(QNAN, QNAN, 1'b1, 1'b0);
    do_op(SNAN, SNAN, 1'b0, 1'b0);
    do_op(QNAN, SNAN, 1'b1, 1'b0);
    // sticky through quiet and ordinary ops (R5)
    do_op(QNAN, ANYV, 1'b1, 1'b0);
    do_op(64'h4000_0000_0000_0000, 64'hC000_0000_0000_0000, 1'b0, 1'b0);
    // clear and set in the same cycle (R6)
    do_op(SNAN, ANYV, 1'b0, 1'b1);
    do_op(SNAN, SNAN, 1'b1, 1'b1);
    // signed zeros (R8)
    do_op(PZERO, NZERO, 1'b0, 1'b0);
    do_op(NZERO, PZERO, 1'b0, 1'b0);
    do_op(PZERO, NZERO, 1'b1, 1'b0);
    do_op(NZERO, PZERO, 1'b1, 1'b0);
    // infinities (R9)
    do_op(PINF, ANYV, 1'b1, 1'b0);
    do_op(NINF, 64'hFFEF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    do_op(PINF, NINF, 1'b0, 1'b0);
    check("R9", {63'd0, invalid_flag}, 64'd0);
    // negative magnitudes reversed (R7)
    do_op(64'hC008_0000_0000_0000, 64'hC000_0000_0000_0000, 1'b0, 1'b0);
    do_op(64'hC008_0000_0000_0000, 64'hC000_0000_0000_0000, 1'b1, 1'b0);

    // idle cycle: valid drops, result holds (R10)
    held = result;
    @(negedge clk);
    check("R10", {63'd0, res_valid}, 64'd0);
    check("R10", result, held);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b;
      a = gen_operand();
      b = ($urandom % 10 == 0) ? a : gen_operand();
      do_op(a, b, 1'($urandom % 2), ($urandom % 9 == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule